// File: doc/BRIEF.md
# Program-Busy Status Read Multiplexer

This block is the read-side data path of a byte-wide nonvolatile memory. The memory reports the progress of its internal program cycle through ordinary reads, so a host can poll it without extra pins. When no program cycle is running, the block passes the array's read data to the bus. The bus is driven only while chip-enable and output-enable are both active and write-enable is inactive. The array storage and the write-path control are outside this block. They supply the array read data, the data byte on the write bus, and a busy flag.

While busy is high, a read returns a status byte instead of plain data, and it carries two independent completion indicators. The top bit is the inverse of the top bit of the most recently written byte. The next bit flips from one read access to the next. The low bits still carry the array content at the addressed location. A host can detect completion in either of two ways: it waits until the top bit matches the data it wrote, or it waits until two successive reads return the same value in the next bit. Reads act as polling reads during any program period, including one the write path starts after rejecting a write. Polling may begin at any point in that period.

All control inputs are active low and synchronous to `clk`. The bus value is combinational from the current inputs and a few state registers, so a status change is visible in the same cycle that busy changes.

Top module: `poll_read_mux`

## Requirements
- R1: `dq_oe` is 1 exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1. Every other combination leaves the bus undriven.
- R2: While `dq_oe` is 0, `dq_out` is all zeros.
- R3: While `busy` is 0 and the bus is driven, `dq_out` equals `arr_data` on all bits.
- R4: While `busy` is 1 and the bus is driven, `dq_out[DATA_W-1]` (bit 7 at default width) is the inverse of the top bit of the reference byte.
- R5: While `busy` is 1 and the bus is driven, `dq_out[DATA_W-3:0]` (bits 5..0 at default width) equals the same bits of `arr_data`.
- R6: While `busy` is 1, `dq_out[DATA_W-2]` (bit 6 at default width) shows a toggle state. The toggle state reads 0 in the cycle `busy` rises and on every read until a read access ends. It inverts at each clock edge where `busy` is 1 and the condition `ce_n`=0 and `oe_n`=0 was true in the previous cycle and is false now. If `busy` rises at the same edge, the toggle resets to 0 and does not invert.
- R7: Within one continuous read access while `busy` stays 1, the toggle bit and the polling bit do not change from cycle to cycle. The toggle state also holds while `busy` is 0.
- R8: The reference byte is the `wr_data` value at the last clock edge where `ce_n`=0, `we_n`=0 and `oe_n`=1. This includes edges while `busy` is 1. After reset, and with no such edge since, the reference byte is 0x00, so a busy read shows 1 in the top bit.
- R9: The choice between status and true data follows `busy` in the same cycle, even in the middle of a read access. True data returns in the cycle `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| arr_data | input | DATA_W | Array content at the current read address |
| wr_data | input | DATA_W | Data byte on the write bus |
| busy | input | 1 | Program cycle in progress |
| dq_out | output | DATA_W | Read data toward the tristate pad |
| dq_oe | output | 1 | Output enable for the tristate pad |

## Verification
The bench builds the block with the default `DATA_W` of 8, so bit 7 is the polling bit, bit 6 is the toggle bit and bits 5..0 pass through. This width covers every field the status byte has. The random steps mix every combination of the three strobes with busy edges. This exercises the cases where a read access ends at the same edge that busy rises, where a write strobe arrives while busy is high, and where busy changes in the middle of a read.

// File: rtl/poll_read_mux.sv
module poll_read_mux #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [DATA_W-1:0] arr_data,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  logic              rd_cond, wr_cond, rd_end, busy_rise;
  logic              rd_q, busy_q, tog_q, tog_now;
  logic [DATA_W-1:0] ref_q, stat;

  assign rd_cond   = !ce_n && !oe_n;
  assign wr_cond   = !ce_n && !we_n && oe_n;
  assign rd_end    = rd_q && !rd_cond;
  assign busy_rise = busy && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      busy_q <= 1'b0;
      tog_q  <= 1'b0;
      ref_q  <= '0;
    end else begin
      rd_q   <= rd_cond;
      busy_q <= busy;
      if (wr_cond)
        ref_q <= wr_data;
      if (busy_rise)
        tog_q <= 1'b0;
      else if (busy && rd_end)
        tog_q <= !tog_q;
    end
  end

  assign tog_now = busy_rise ? 1'b0 : tog_q;

  always_comb begin
    stat           = arr_data;
    stat[POLL_BIT] = !ref_q[POLL_BIT];
    stat[TOG_BIT]  = tog_now;
  end

  assign dq_oe  = rd_cond && we_n;
  assign dq_out = !dq_oe ? '0 : (busy ? stat : arr_data);
endmodule

// File: rtl/poll_read_mux_chk.sv
module poll_read_mux_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic [DATA_W-1:0] arr_data,
  input logic              busy,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe
);
  p_inhibit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n || !we_n) |-> !dq_oe);

  p_quiet_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_out == '0));

  p_true_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && !busy) |-> (dq_out == arr_data));

  p_low_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && busy) |-> (dq_out[DATA_W-3:0] == arr_data[DATA_W-3:0]));

  p_tog_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && dq_oe) |-> !dq_out[DATA_W-2]);

  p_status_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && dq_oe && $past(dq_oe)) |->
      ($stable(dq_out[DATA_W-2]) && $stable(dq_out[DATA_W-1])));
endmodule

bind poll_read_mux poll_read_mux_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .arr_data(arr_data), .busy(busy), .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/poll_read_mux_tb.sv
module poll_read_mux_tb;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, busy = 1'b0;
  logic [DW-1:0] arr_data = '0, wr_data = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  int n_chk = 0, n_fail = 0;
  logic          m_tog = 1'b0, m_rd = 1'b0, m_busy = 1'b0;
  logic [DW-1:0] m_ref = '0;

  always #4 clk = !clk;

  poll_read_mux #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .arr_data(arr_data), .wr_data(wr_data), .busy(busy),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic logic [DW-1:0] exp_dq(logic b, logic [DW-1:0] a,
                                           logic [DW-1:0] r, logic t);
    logic [DW-1:0] v;
    v = a;
    if (b) begin
      v[DW-1] = !r[DW-1];
      v[DW-2] = t;
    end
    return v;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(logic c, logic o, logic w, logic b,
                      logic [DW-1:0] a, logic [DW-1:0] wd);
    logic rd, wr, rise, t, drv;
    logic [DW-1:0] e;
    @(negedge clk);
    ce_n = c; oe_n = o; we_n = w; busy = b; arr_data = a; wr_data = wd;
    #1;
    rd   = !c && !o;
    wr   = !c && !w && o;
    drv  = rd && w;
    rise = b && !m_busy;
    t    = rise ? 1'b0 : m_tog;
    chk("R1 drive", {7'd0, dq_oe}, {7'd0, drv});
    if (!drv) chk("R2 quiet bus", dq_out, '0);
    else if (!b) chk("R3 true data", dq_out, a);
    else begin
      e = exp_dq(b, a, m_ref, t);
      chk("R4 poll bit", {7'd0, dq_out[DW-1]}, {7'd0, e[DW-1]});
      chk("R6 toggle bit", {7'd0, dq_out[DW-2]}, {7'd0, e[DW-2]});
      chk("R5 low bits", {2'd0, dq_out[DW-3:0]}, {2'd0, e[DW-3:0]});
    end
    if (rise) m_tog = 1'b0;
    else if (b && m_rd && !rd) m_tog = !m_tog;
    if (wr) m_ref = wd;
    m_rd = rd;
    m_busy = b;
  endtask

  task automatic rd(logic b, logic [DW-1:0] a);
    step(1'b0, 1'b0, 1'b1, b, a, 8'h00);
  endtask
  task automatic idle(logic b);
    step(1'b1, 1'b1, 1'b1, b, 8'h5A, 8'h00);
  endtask
  task automatic wr(logic b, logic [DW-1:0] d);
    step(1'b0, 1'b1, 1'b0, b, 8'h00, d);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset no drive", {7'd0, dq_oe}, 8'd0);
    chk("R2 reset quiet", dq_out, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: no write since reset, reference 0x00 -> poll bit 1
    idle(1'b1);
    rd(1'b1, 8'h00);
    chk("R8 reset reference poll bit", {7'd0, dq_out[7]}, 8'd1);
    idle(1'b1);
    // R6: toggle advanced once after the read ended
    rd(1'b1, 8'h3F);
    chk("R6 toggle after one access", {7'd0, dq_out[6]}, 8'd1);
    // R7: stays constant through a continuous read
    rd(1'b1, 8'h00);
    rd(1'b1, 8'hFF);
    chk("R7 toggle held in access", {7'd0, dq_out[6]}, 8'd1);
    idle(1'b1);
    rd(1'b1, 8'h00);
    chk("R6 toggle second flip", {7'd0, dq_out[6]}, 8'd0);
    // R9: busy drops mid read -> true data at once
    rd(1'b0, 8'hC3);
    chk("R9 true data on busy fall", dq_out, 8'hC3);
    idle(1'b0);
    // R8/R4: write 0x80 then busy -> poll bit 0
    wr(1'b0, 8'h80);
    idle(1'b0);
    rd(1'b0, 8'h11);
    // R9: busy rises mid read
    rd(1'b1, 8'h11);
    chk("R9 status on busy rise", dq_out, 8'h11);
    chk("R4 poll bit after write 80", {7'd0, dq_out[7]}, 8'd0);
    // R8: write during busy updates reference
    idle(1'b1);
    wr(1'b1, 8'h7F);
    idle(1'b1);
    rd(1'b1, 8'h00);
    chk("R8 reference update while busy", {7'd0, dq_out[7]}, 8'd1);
    // R6: read end coincides with busy rise -> reset wins
    rd(1'b0, 8'h00);
    idle(1'b1);
    rd(1'b1, 8'h00);
    chk("R6 reset beats advance", {7'd0, dq_out[6]}, 8'd0);
    // R7: toggle holds across idle reads
    idle(1'b1);
    rd(1'b0, 8'h00);
    idle(1'b0);
    rd(1'b0, 8'h00);
    idle(1'b0);
    // R1: write-inhibit combinations
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'hAA, 8'h00);
    chk("R1 we low blocks drive", {7'd0, dq_oe}, 8'd0);

    for (int i = 0; i < 2000; i++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      case (op)
        3'd0, 3'd1, 3'd2: rd(busy, 8'($urandom));
        3'd3: idle(busy);
        3'd4: wr(busy, 8'($urandom));
        3'd5: step(1'($urandom), 1'($urandom), 1'($urandom), busy,
                   8'($urandom), 8'($urandom));
        default: step(ce_n, oe_n, we_n, !busy, 8'($urandom), 8'h00);
      endcase
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule